// File: doc/BRIEF.md
# One-Step Majority Decoder for a Locally Recoverable Cube Code

This block corrects a 64-bit binary codeword in one clock. The code arranges the 64 bits as a 4x4x4 cube. Every straight run of four bits parallel to an axis has even parity. Because of this, each bit can be rebuilt in three independent ways: the XOR of the other three bits on its x-line, on its y-line, or on its z-line. These three lines meet only at the bit being rebuilt, so one corrupted bit elsewhere can spoil at most one of the rebuilt values.

For every bit at once, the decoder forms the three rebuilt values. It adds the received bit as a fourth vote and takes the majority. A per-bit erasure mask marks untrusted positions. A line that holds an erased bit gives no vote, and an erased target gives no vote of its own.

The decision logic is purely combinational. The corrected word is registered together with a valid strobe and two per-word flags. One flag reports that a correction was made. The other reports that some bit had no usable vote.

Top module: `lrc_mlg_decoder`

## Requirements
- R1: `out_valid` equals `in_valid` as sampled at the previous rising clock edge. While `rst_n` is low, `out_valid`, `out_word`, `out_fix` and `out_fail` are all 0.
- R2: Bit index is x + 4y + 16z, with x, y, z in 0..3. A bit's recovery estimate along one axis is the XOR of the other three bits on its line along that axis.
- R3: Each non-abstaining estimate is a vote, and so is the received bit when it is not erased. The output bit is 1 when the votes for 1 outnumber the votes for 0. It is 0 when the votes for 0 outnumber the votes for 1.
- R4: When the votes for 1 and for 0 are equal and at least one vote exists, the output bit equals the received bit.
- R5: An estimate whose line holds any erased bit (other than the target) abstains. A target whose erasure bit is 1 gives no vote of its own.
- R6: When a bit has no votes at all, that output bit is 0 and `out_fail` is 1 for the word.
- R7: `out_fix` is 1 exactly when the output word differs from the received word in at least one position.
- R8: A valid codeword with exactly one bit flipped and no erasures is restored to the original codeword.
- R9: A valid codeword with two bits flipped, where the two bits share no axis line, is restored to the original codeword.
- R10: A valid codeword with one erased bit (holding any value) and one flipped bit at another position is restored to the original codeword.
- R11: When `in_valid` is low, `out_word`, `out_fix` and `out_fail` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_word` and `in_erase` for capture |
| in_word | input | 64 | Received word, bit x+4y+16z |
| in_erase | input | 64 | Erasure mask, 1 marks an untrusted bit |
| out_valid | output | 1 | Registered result is new this cycle |
| out_word | output | 64 | Decoded word |
| out_fix | output | 1 | Decoded word differs from the received word |
| out_fail | output | 1 | At least one bit had no vote and was forced to 0 |

## Verification
Abstention and correction can act in the same word: an erased position must be rebuilt while a flipped bit elsewhere is voted down, and the erasure removes exactly the line votes that the flip needs to lose. The bench provokes this by placing one random erasure and one random flip in each fresh codeword. Some of these pairs share a line and some do not. Each result is judged against the original codeword and against a behavioural vote-counting model. The fail flag is provoked by erasing a bit together with one member of each of its three lines. Back-to-back words and idle gaps then check that the flags hold steady.

// File: rtl/lrc_mlg_decoder.sv
module lrc_mlg_decoder #(
  parameter int SIDE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [SIDE*SIDE*SIDE-1:0]   in_word,
  input  logic [SIDE*SIDE*SIDE-1:0]   in_erase,
  output logic                        out_valid,
  output logic [SIDE*SIDE*SIDE-1:0]   out_word,
  output logic                        out_fix,
  output logic                        out_fail
);
  localparam int N    = SIDE * SIDE * SIDE;
  localparam int AXES = 3;
  localparam int CW   = $clog2(AXES + 2);

  logic [N-1:0] nxt_word;
  logic [N-1:0] nxt_fail;

  function automatic logic [1:0] line_vote(input logic [N-1:0] w, input logic [N-1:0] e,
                                           input int base, input int stride, input int skip);
    logic p;
    logic x;
    p = 1'b0;
    x = 1'b0;
    for (int k = 0; k < SIDE; k++) begin
      if (k != skip) begin
        p = p ^ w[base + k * stride];
        x = x | e[base + k * stride];
      end
    end
    return {x, p};
  endfunction

  for (genvar gz = 0; gz < SIDE; gz++) begin : g_z
    for (genvar gy = 0; gy < SIDE; gy++) begin : g_y
      for (genvar gx = 0; gx < SIDE; gx++) begin : g_x
        localparam int B = gx + SIDE * gy + SIDE * SIDE * gz;
        logic [AXES-1:0] est;
        logic [AXES-1:0] abst;
        logic [AXES:0]   vld;
        logic [AXES:0]   val;
        logic [CW-1:0]   ones;
        logic [CW-1:0]   tot;

        for (genvar a = 0; a < AXES; a++) begin : g_axis
          localparam int STRIDE = (a == 0) ? 1 : (a == 1) ? SIDE : SIDE * SIDE;
          localparam int POS    = (a == 0) ? gx : (a == 1) ? gy : gz;
          logic [1:0] lv;
          assign lv      = line_vote(in_word, in_erase, B - POS * STRIDE, STRIDE, POS);
          assign est[a]  = lv[0];
          assign abst[a] = lv[1];
        end

        assign vld  = {~in_erase[B], ~abst};
        assign val  = {in_word[B], est};
        assign ones = CW'($countones(vld & val));
        assign tot  = CW'($countones(vld));

        assign nxt_fail[B] = (tot == '0);
        assign nxt_word[B] = (tot == '0)                    ? 1'b0 :
                             ({ones, 1'b0} > {1'b0, tot})   ? 1'b1 :
                             ({ones, 1'b0} < {1'b0, tot})   ? 1'b0 :
                                                              in_word[B];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_fix   <= 1'b0;
      out_fail  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= nxt_word;
        out_fix  <= |(nxt_word ^ in_word);
        out_fail <= |nxt_fail;
      end
    end
  end
endmodule

// File: rtl/lrc_mlg_decoder_sva.sv
module lrc_mlg_decoder_sva #(
  parameter int SIDE = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      in_valid,
  input logic [SIDE*SIDE*SIDE-1:0] in_word,
  input logic [SIDE*SIDE*SIDE-1:0] in_erase,
  input logic                      out_valid,
  input logic [SIDE*SIDE*SIDE-1:0] out_word,
  input logic                      out_fix,
  input logic                      out_fail
);
  a_r1_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_word) && $stable(out_fix) && $stable(out_fail)));

  a_r7_clean_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(rst_n)) ##1 !out_fix |-> out_word == $past(in_word));

  a_r6_fail_needs_erasure: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_erase == '0) |=> !out_fail);
endmodule

bind lrc_mlg_decoder lrc_mlg_decoder_sva #(.SIDE(SIDE)) u_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_erase(in_erase),
  .out_valid(out_valid), .out_word(out_word), .out_fix(out_fix), .out_fail(out_fail)
);

// File: tb/tb_lrc_mlg_decoder.sv
module tb_lrc_mlg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic [63:0] in_erase = '0;
  logic        out_valid;
  logic [63:0] out_word;
  logic        out_fix;
  logic        out_fail;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  string       cur_tag = "R1";
  logic        cur_gold_en = 1'b0;
  logic [63:0] cur_gold = '0;

  string       exp_tag = "R1";
  logic        exp_valid = 1'b0;
  logic [63:0] exp_word = '0;
  logic        exp_fix = 1'b0;
  logic        exp_fail = 1'b0;
  logic        exp_gold_en = 1'b0;
  logic [63:0] exp_gold = '0;

  lrc_mlg_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_erase(in_erase),
    .out_valid(out_valid), .out_word(out_word), .out_fix(out_fix), .out_fail(out_fail)
  );

  always #2 clk = ~clk;

  function automatic int idx(int x, int y, int z);
    return x + 4 * y + 16 * z;
  endfunction

  function automatic logic [63:0] encode(logic [26:0] msg);
    logic [63:0] c;
    c = '0;
    for (int z = 0; z < 3; z++)
      for (int y = 0; y < 3; y++)
        for (int x = 0; x < 3; x++) c[idx(x, y, z)] = msg[x + 3 * y + 9 * z];
    for (int z = 0; z < 3; z++)
      for (int y = 0; y < 3; y++) c[idx(3, y, z)] = c[idx(0, y, z)] ^ c[idx(1, y, z)] ^ c[idx(2, y, z)];
    for (int z = 0; z < 3; z++)
      for (int x = 0; x < 4; x++) c[idx(x, 3, z)] = c[idx(x, 0, z)] ^ c[idx(x, 1, z)] ^ c[idx(x, 2, z)];
    for (int y = 0; y < 4; y++)
      for (int x = 0; x < 4; x++) c[idx(x, y, 3)] = c[idx(x, y, 0)] ^ c[idx(x, y, 1)] ^ c[idx(x, y, 2)];
    return c;
  endfunction

  task automatic model(input logic [63:0] w, input logic [63:0] e,
                       output logic [63:0] o, output logic fx, output logic fl);
    fl = 1'b0;
    for (int b = 0; b < 64; b++) begin
      int c[3];
      int for1 = 0;
      int for0 = 0;
      c[0] = b % 4; c[1] = (b / 4) % 4; c[2] = b / 16;
      if (!e[b]) begin
        if (w[b]) for1++; else for0++;
      end
      for (int a = 0; a < 3; a++) begin
        logic par = 1'b0;
        logic bad = 1'b0;
        for (int k = 0; k < 4; k++) begin
          int p[3];
          int j;
          p = c;
          p[a] = k;
          j = idx(p[0], p[1], p[2]);
          if (j != b) begin
            par = par ^ w[j];
            bad = bad | e[j];
          end
        end
        if (!bad) begin
          if (par) for1++; else for0++;
        end
      end
      if (for1 + for0 == 0) begin o[b] = 1'b0; fl = 1'b1; end
      else if (for1 > for0) o[b] = 1'b1;
      else if (for0 > for1) o[b] = 1'b0;
      else o[b] = w[b];
    end
    fx = (o != w);
  endtask

  function automatic bit same_line(int p, int q);
    int eq = 0;
    if (p % 4 == q % 4) eq++;
    if ((p / 4) % 4 == (q / 4) % 4) eq++;
    if (p / 16 == q / 16) eq++;
    return eq >= 2;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 1'b0 && out_word == '0 && !out_fix && !out_fail, "R1", "reset state",
            {out_valid, out_fix, out_fail, out_word[60:0]}, '0);
      exp_valid <= 1'b0; exp_word <= '0; exp_fix <= 1'b0; exp_fail <= 1'b0; exp_gold_en <= 1'b0;
    end else begin
      logic [63:0] mo;
      logic mfx, mfl;
      check(out_valid == exp_valid, "R1", "out_valid", 64'(out_valid), 64'(exp_valid));
      check(out_word == exp_word, exp_tag, "out_word", out_word, exp_word);
      check(out_fix == exp_fix, (exp_tag == "R11") ? "R11" : "R7", "out_fix", 64'(out_fix), 64'(exp_fix));
      check(out_fail == exp_fail, (exp_tag == "R11") ? "R11" : "R6", "out_fail", 64'(out_fail), 64'(exp_fail));
      if (exp_valid && exp_gold_en)
        check(out_word == exp_gold, exp_tag, "vs original codeword", out_word, exp_gold);
      exp_valid <= in_valid;
      if (in_valid) begin
        model(in_word, in_erase, mo, mfx, mfl);
        exp_word <= mo; exp_fix <= mfx; exp_fail <= mfl;
        exp_gold_en <= cur_gold_en; exp_gold <= cur_gold; exp_tag <= cur_tag;
      end else begin
        exp_gold_en <= 1'b0; exp_tag <= "R11";
      end
    end
  end

  task automatic send(logic [63:0] w, logic [63:0] e, string tag, logic gen, logic [63:0] g);
    in_valid = 1'b1; in_word = w; in_erase = e;
    cur_tag = tag; cur_gold_en = gen; cur_gold = g;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0; in_word = {$urandom, $urandom}; in_erase = {$urandom, $urandom};
      @(posedge clk); #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2);

    // R8 and R7: every single flip position, several messages
    for (int m = 0; m < 4; m++) begin
      logic [63:0] cw;
      cw = encode(27'($urandom));
      send(cw, '0, "R7", 1'b1, cw);
      for (int b = 0; b < 64; b++) send(cw ^ (64'd1 << b), '0, "R8", 1'b1, cw);
    end
    idle(3);

    // R9: two flips sharing no line
    for (int t = 0; t < 150; t++) begin
      logic [63:0] cw;
      int p, q;
      cw = encode(27'($urandom));
      p = $urandom_range(63);
      do q = $urandom_range(63); while (q == p || same_line(p, q));
      send(cw ^ (64'd1 << p) ^ (64'd1 << q), '0, "R9", 1'b1, cw);
    end

    // R10: one erasure plus one error, both in the same word
    for (int t = 0; t < 150; t++) begin
      logic [63:0] cw, w;
      int p, q;
      cw = encode(27'($urandom));
      p = $urandom_range(63);
      do q = $urandom_range(63); while (q == p);
      w = cw ^ (64'd1 << q);
      w[p] = 1'($urandom);
      send(w, 64'd1 << p, "R10", 1'b1, cw);
      if (t % 37 == 0) idle(1);
    end

    // R4: two flips on one line give ties at the flipped bits
    for (int t = 0; t < 30; t++) begin
      logic [63:0] cw;
      cw = encode(27'($urandom));
      send(cw ^ (64'd1 << idx(0, t % 4, 1)) ^ (64'd1 << idx(2, t % 4, 1)), '0, "R4", 1'b0, '0);
    end

    // R6: bit and one member of each of its lines erased
    for (int t = 0; t < 16; t++) begin
      int x, y, z;
      logic [63:0] e;
      x = $urandom_range(3); y = $urandom_range(3); z = $urandom_range(3);
      e = (64'd1 << idx(x, y, z)) | (64'd1 << idx((x + 1) % 4, y, z)) |
          (64'd1 << idx(x, (y + 1) % 4, z)) | (64'd1 << idx(x, y, (z + 1) % 4));
      send({$urandom, $urandom} | (64'd1 << idx(x, y, z)), e, "R6", 1'b0, '0);
    end

    // R2, R3, R5: arbitrary words and mask densities
    for (int t = 0; t < 200; t++) begin
      logic [63:0] e;
      e = (t % 3 == 0) ? '0 : ((t % 3 == 1) ? {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
                                           : {$urandom, $urandom} & {$urandom, $urandom});
      send({$urandom, $urandom}, e, (e == '0) ? "R3" : "R5", 1'b0, '0);
      if (t % 50 == 0) send(encode(27'($urandom)), '0, "R2", 1'b0, '0);
    end
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL R1 watchdog: actual=%0d expected<=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule